// File: doc/BRIEF.md
# DDR2 Command Decoder with Power-State Tracking

This block observes a DDR2 command bus and turns each clock cycle into one named command, in the way a memory model or a bus monitor would. At every rising clock edge it samples clock enable, chip select, the row and column strobes, write enable, the bank address and the address lines. It keeps the clock-enable value seen at the previous edge. The pair of clock-enable values, together with the strobe pattern, selects the command.

A small power-state machine follows the device through the active, power-down and self-refresh states. It does this because a deselect or no-operation on a clock-enable rise means a different thing depending on the state being left. The decoded command, its bank, its row, column or mode opcode, an auto-precharge flag, an illegal-pattern flag and the power state are all presented from one output register stage. They are valid in the cycle after the edge that sampled the pins. The reset input is asynchronous and active low, and its release is expected to be synchronised to the clock outside the block.

Top module: `ddr2_cmd_decoder`

## Requirements
- R1: While reset is asserted, cmd is 0 (none), pwr_state is 0 (active) and bank, addr, auto_pre and illegal are all 0. The remembered clock enable restarts as high, so the first edge after reset with clock enable high decodes as a steady-high cycle.
- R2: With clock enable high at both the previous and current edge, cs_n high decodes to cmd 1 (deselect), and cs_n low with ras_n, cas_n and we_n all high decodes to cmd 2 (no-operation).
- R3: With clock enable steady high and cs_n, ras_n, cas_n and we_n all low, the cycle decodes to cmd 3 (mode register set) when ba[0] is 0 and to cmd 4 (extended mode register set) when ba[0] is 1. cmd_bank carries ba and cmd_addr carries the full address as the opcode.
- R4: With clock enable steady high and cs_n, ras_n and cas_n low while we_n is high, the cycle decodes to cmd 5 (auto refresh) and the power state stays active.
- R5: The refresh pattern of R4 sampled with clock enable falling (high before, low now) decodes to cmd 6 (self-refresh entry) and sets pwr_state to 2 (self-refresh).
- R6: With clock enable steady high and ras_n low, cas_n high and we_n low, the cycle decodes to cmd 9 (precharge all, bank 0) when address bit 10 is high, and to cmd 8 (single-bank precharge, cmd_bank = ba) when address bit 10 is low. cmd_addr is 0 in both cases.
- R7: With clock enable steady high and ras_n low while cas_n and we_n are high, the cycle decodes to cmd 10 (activate), with cmd_bank = ba and cmd_addr = the full row address.
- R8: With clock enable steady high and ras_n high, cas_n low, the cycle decodes to cmd 11 (read) when we_n is high and to cmd 12 (write) when we_n is low. cmd_bank = ba, cmd_addr = address bits 9..0 zero-extended, and auto_pre = address bit 10.
- R9: A deselect or no-operation pattern sampled with clock enable falling decodes to cmd 13 (power-down entry) and sets pwr_state to 1 (power-down).
- R10: A deselect or no-operation pattern sampled with clock enable rising decodes to cmd 7 (self-refresh exit) when pwr_state is 2 and to cmd 14 (power-down exit) otherwise. In both cases pwr_state returns to 0, even when the rise follows a single low cycle.
- R11: An edge with clock enable low at both the previous and current sample yields cmd 0, illegal 0, and leaves pwr_state unchanged whatever the other pins carry.
- R12: The pattern ras_n high, cas_n high, we_n low with cs_n low and clock enable steady high is illegal. So is any pattern on a clock-enable fall other than those of R5 and R9, and any pattern on a rise other than deselect or no-operation. An illegal cycle gives cmd 15 with illegal 1 and leaves pwr_state unchanged.
- R13: Each result appears on the outputs one cycle after the edge that sampled the pins and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address lines |
| cmd | output | 4 | Decoded command code |
| cmd_bank | output | BANK_W | Bank of the decoded command |
| cmd_addr | output | ADDR_W | Row, column or opcode |
| auto_pre | output | 1 | Auto-precharge requested by a read or write |
| illegal | output | 1 | Sampled pattern has no legal meaning |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |

## Verification
The checker takes the pins to be stable around each rising edge and the reset to be released away from an edge. It also keeps its own copy of the previous clock enable, starting high as the decoder does, so it does not depend on the pin history from before reset. The bench changes every input only at falling edges and releases reset at a falling edge. It walks the clock enable through every pair of previous and current values, including rises straight after one low cycle, so that each property's antecedent is reached with inputs that meet these conditions.

// File: rtl/ddr2dec_pkg.sv
package ddr2dec_pkg;

  typedef enum logic [3:0] {
    CMD_NONE     = 4'd0,
    CMD_DESELECT = 4'd1,
    CMD_NOP      = 4'd2,
    CMD_MODE     = 4'd3,
    CMD_EXTMODE  = 4'd4,
    CMD_REFRESH  = 4'd5,
    CMD_SR_ENTER = 4'd6,
    CMD_SR_EXIT  = 4'd7,
    CMD_PRE_ONE  = 4'd8,
    CMD_PRE_ALL  = 4'd9,
    CMD_ACTIVATE = 4'd10,
    CMD_READ     = 4'd11,
    CMD_WRITE    = 4'd12,
    CMD_PD_ENTER = 4'd13,
    CMD_PD_EXIT  = 4'd14,
    CMD_ILLEGAL  = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_DOWN   = 2'd1,
    PWR_SELF   = 2'd2
  } pwr_e;

  localparam int unsigned AP_BIT = 10;
  localparam int unsigned COL_W  = 10;

endpackage

// File: rtl/ddr2dec_cke_history.sv
module ddr2dec_cke_history (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic cke_prev
);

  logic prev_d;

  always_comb begin
    prev_d = cke;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev <= 1'b1;
    end else begin
      cke_prev <= prev_d;
    end
  end

endmodule

// File: rtl/ddr2dec_classify.sv
module ddr2dec_classify
  import ddr2dec_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 14
) (
  input  logic              cke_prev,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  pwr_e              pwr_now,
  output cmd_e              cmd_d,
  output logic [BANK_W-1:0] bank_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic              ap_d
);

  logic [2:0] strobes;
  logic       steady_hi;
  logic       falling;
  logic       rising;
  logic       idle_pat;
  logic       refresh_pat;

  always_comb begin
    strobes     = {ras_n, cas_n, we_n};
    steady_hi   = cke_prev & cke;
    falling     = cke_prev & ~cke;
    rising      = ~cke_prev & cke;
    idle_pat    = cs_n | (strobes == 3'b111);
    refresh_pat = ~cs_n & (strobes == 3'b001);
  end

  always_comb begin
    cmd_d  = CMD_NONE;
    bank_d = '0;
    addr_d = '0;
    ap_d   = 1'b0;
    if (steady_hi) begin
      if (cs_n) begin
        cmd_d = CMD_DESELECT;
      end else begin
        unique case (strobes)
          3'b000: begin
            cmd_d  = ba[0] ? CMD_EXTMODE : CMD_MODE;
            bank_d = ba;
            addr_d = addr;
          end
          3'b001: cmd_d = CMD_REFRESH;
          3'b010: begin
            if (addr[AP_BIT]) begin
              cmd_d = CMD_PRE_ALL;
            end else begin
              cmd_d  = CMD_PRE_ONE;
              bank_d = ba;
            end
          end
          3'b011: begin
            cmd_d  = CMD_ACTIVATE;
            bank_d = ba;
            addr_d = addr;
          end
          3'b100, 3'b101: begin
            cmd_d  = strobes[0] ? CMD_READ : CMD_WRITE;
            bank_d = ba;
            addr_d = ADDR_W'(addr[COL_W-1:0]);
            ap_d   = addr[AP_BIT];
          end
          3'b110: cmd_d = CMD_ILLEGAL;
          default: cmd_d = CMD_NOP;
        endcase
      end
    end else if (falling) begin
      if (idle_pat) begin
        cmd_d = CMD_PD_ENTER;
      end else if (refresh_pat) begin
        cmd_d = CMD_SR_ENTER;
      end else begin
        cmd_d = CMD_ILLEGAL;
      end
    end else if (rising) begin
      if (idle_pat) begin
        cmd_d = (pwr_now == PWR_SELF) ? CMD_SR_EXIT : CMD_PD_EXIT;
      end else begin
        cmd_d = CMD_ILLEGAL;
      end
    end
  end

endmodule

// File: rtl/ddr2dec_pwr_track.sv
module ddr2dec_pwr_track
  import ddr2dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd_d,
  output pwr_e pwr_q
);

  pwr_e pwr_d;

  always_comb begin
    pwr_d = pwr_q;
    case (cmd_d)
      CMD_PD_ENTER:             pwr_d = PWR_DOWN;
      CMD_SR_ENTER:             pwr_d = PWR_SELF;
      CMD_PD_EXIT, CMD_SR_EXIT: pwr_d = PWR_ACTIVE;
      default:                  pwr_d = pwr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= PWR_ACTIVE;
    end else begin
      pwr_q <= pwr_d;
    end
  end

endmodule

// File: rtl/ddr2_cmd_decoder.sv
module ddr2_cmd_decoder
  import ddr2dec_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              auto_pre,
  output logic              illegal,
  output logic [1:0]        pwr_state
);

  logic              cke_prev;
  pwr_e              pwr_q;
  cmd_e              cmd_d;
  logic [BANK_W-1:0] bank_d;
  logic [ADDR_W-1:0] addr_d;
  logic              ap_d;
  logic              ill_d;

  cmd_e              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ap_q;
  logic              ill_q;

  ddr2dec_cke_history u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cke_prev (cke_prev)
  );

  ddr2dec_classify #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
  ) u_class (
    .cke_prev (cke_prev),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .addr     (addr),
    .pwr_now  (pwr_q),
    .cmd_d    (cmd_d),
    .bank_d   (bank_d),
    .addr_d   (addr_d),
    .ap_d     (ap_d)
  );

  ddr2dec_pwr_track u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_d (cmd_d),
    .pwr_q (pwr_q)
  );

  always_comb begin
    ill_d = (cmd_d == CMD_ILLEGAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NONE;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
      ap_q   <= ap_d;
      ill_q  <= ill_d;
    end
  end

  assign cmd       = cmd_q;
  assign cmd_bank  = bank_q;
  assign cmd_addr  = addr_q;
  assign auto_pre  = ap_q;
  assign illegal   = ill_q;
  assign pwr_state = pwr_q;

endmodule

// File: rtl/ddr2_cmd_decoder_chk.sv
module ddr2_cmd_decoder_chk #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        cmd,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              auto_pre,
  input logic              illegal,
  input logic [1:0]        pwr_state
);

  logic seen_cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_cke <= 1'b1;
    end else begin
      seen_cke <= cke;
    end
  end

  // R2
  a_r2_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cke && cke && !cs_n && ras_n && cas_n && we_n) |=> (cmd == 4'd2));

  // R5
  a_r5_sr_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cke && !cke && !cs_n && !ras_n && !cas_n && we_n) |=> (pwr_state == 2'd2 && cmd == 4'd6));

  // R8
  a_r8_read_ap: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cke && cke && !cs_n && ras_n && !cas_n && we_n && addr[10]) |=> (cmd == 4'd11 && auto_pre));

  // R9
  a_r9_pd_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cke && !cke && cs_n) |=> (cmd == 4'd13 && pwr_state == 2'd1));

  // R10
  a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_cke && cke && cs_n) |=> (pwr_state == 2'd0 && !illegal));

  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_cke && !cke) |=> ($stable(pwr_state) && cmd == 4'd0 && !illegal));

  // R12
  a_r12_bad_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cke && cke && !cs_n && ras_n && cas_n && !we_n) |=> (illegal && $stable(pwr_state)));

  // R13
  a_r13_no_ap_on_act: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cke && cke && !cs_n && !ras_n && cas_n && we_n) |=> (cmd == 4'd10 && !auto_pre && cmd_bank == $past(ba)));

endmodule

bind ddr2_cmd_decoder ddr2_cmd_decoder_chk #(
  .BANK_W (BANK_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .cmd       (cmd),
  .cmd_bank  (cmd_bank),
  .cmd_addr  (cmd_addr),
  .auto_pre  (auto_pre),
  .illegal   (illegal),
  .pwr_state (pwr_state)
);

// File: tb/ddr2_cmd_decoder_test.sv
module ddr2_cmd_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        cke;
  logic        cs_n;
  logic        ras_n;
  logic        cas_n;
  logic        we_n;
  logic [1:0]  ba;
  logic [13:0] addr;
  logic [3:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [13:0] cmd_addr;
  logic        auto_pre;
  logic        illegal;
  logic [1:0]  pwr_state;

  int total;
  int bad;

  ddr2_cmd_decoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .cmd       (cmd),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr),
    .auto_pre  (auto_pre),
    .illegal   (illegal),
    .pwr_state (pwr_state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        i_cke;
    logic [3:0]  i_pins;   // cs_n, ras_n, cas_n, we_n
    logic [1:0]  i_ba;
    logic [13:0] i_addr;
    logic [3:0]  e_cmd;
    logic [1:0]  e_pwr;
    logic        e_ill;
    logic        e_ap;
    logic [1:0]  e_bank;
    logic [13:0] e_addr;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'b1111, 2'd0, 14'h0000, 4'd1,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd2},  // R2 deselect
    '{1'b1, 4'b0111, 2'd0, 14'h0000, 4'd2,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd2},  // R2 nop
    '{1'b1, 4'b0000, 2'd0, 14'h0123, 4'd3,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0123, 4'd3},  // R3 mode
    '{1'b1, 4'b0000, 2'd1, 14'h0042, 4'd4,  2'd0, 1'b0, 1'b0, 2'd1, 14'h0042, 4'd3},  // R3 ext mode
    '{1'b1, 4'b0001, 2'd3, 14'h3fff, 4'd5,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd4},  // R4 refresh
    '{1'b1, 4'b0011, 2'd2, 14'h1abc, 4'd10, 2'd0, 1'b0, 1'b0, 2'd2, 14'h1abc, 4'd7},  // R7 activate
    '{1'b1, 4'b0101, 2'd3, 14'h0405, 4'd11, 2'd0, 1'b0, 1'b1, 2'd3, 14'h0005, 4'd8},  // R8 read + ap
    '{1'b1, 4'b0100, 2'd1, 14'h23ff, 4'd12, 2'd0, 1'b0, 1'b0, 2'd1, 14'h03ff, 4'd8},  // R8 write
    '{1'b1, 4'b0010, 2'd2, 14'h0000, 4'd8,  2'd0, 1'b0, 1'b0, 2'd2, 14'h0000, 4'd6},  // R6 one bank
    '{1'b1, 4'b0010, 2'd2, 14'h0400, 4'd9,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd6},  // R6 all banks
    '{1'b1, 4'b0110, 2'd0, 14'h0000, 4'd15, 2'd0, 1'b1, 1'b0, 2'd0, 14'h0000, 4'd12}, // R12 bad strobe
    '{1'b0, 4'b0111, 2'd0, 14'h0000, 4'd13, 2'd1, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd9},  // R9 pd entry
    '{1'b0, 4'b0000, 2'd0, 14'h0000, 4'd0,  2'd1, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd11}, // R11 hold
    '{1'b1, 4'b1000, 2'd0, 14'h0000, 4'd14, 2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd10}, // R10 pd exit
    '{1'b0, 4'b0001, 2'd0, 14'h0000, 4'd6,  2'd2, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd5},  // R5 sr entry
    '{1'b0, 4'b1111, 2'd0, 14'h0000, 4'd0,  2'd2, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd11}, // R11 hold
    '{1'b1, 4'b0111, 2'd0, 14'h0000, 4'd7,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd10}, // R10 sr exit
    '{1'b0, 4'b0011, 2'd0, 14'h0000, 4'd15, 2'd0, 1'b1, 1'b0, 2'd0, 14'h0000, 4'd12}, // R12 bad fall
    '{1'b0, 4'b1111, 2'd0, 14'h0000, 4'd0,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd11}, // R11 hold
    '{1'b1, 4'b0001, 2'd0, 14'h0000, 4'd15, 2'd0, 1'b1, 1'b0, 2'd0, 14'h0000, 4'd12}, // R12 bad rise
    '{1'b1, 4'b0111, 2'd0, 14'h0000, 4'd2,  2'd0, 1'b0, 1'b0, 2'd0, 14'h0000, 4'd2}   // R2 nop
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic [3:0] pins, input logic [1:0] b, input logic [13:0] a);
    cke  = k;
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba   = b;
    addr = a;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    drive(1'b1, 4'b1111, 2'd0, 14'h0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmd", 32'(cmd), 32'd0);
    check("R1 pwr", 32'(pwr_state), 32'd0);
    check("R1 flags", {28'd0, auto_pre, illegal, cmd_bank}, 32'd0);
    rst_n = 1'b1;

    // R13: each vector is checked one edge after it is driven
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].i_cke, VECS[i].i_pins, VECS[i].i_ba, VECS[i].i_addr);
      step();
      check($sformatf("R%0d vec%0d cmd", VECS[i].req, i), 32'(cmd), 32'(VECS[i].e_cmd));
      check($sformatf("R%0d vec%0d pwr", VECS[i].req, i), 32'(pwr_state), 32'(VECS[i].e_pwr));
      check($sformatf("R%0d vec%0d flags", VECS[i].req, i), {30'd0, illegal, auto_pre},
            {30'd0, VECS[i].e_ill, VECS[i].e_ap});
      check($sformatf("R%0d vec%0d bank/addr", VECS[i].req, i), {16'd0, cmd_bank, cmd_addr},
            {16'd0, VECS[i].e_bank, VECS[i].e_addr});
    end

    // R10: self-refresh left after a single low cycle
    drive(1'b0, 4'b0001, 2'd0, 14'h0);
    step();
    drive(1'b1, 4'b1111, 2'd0, 14'h0);
    step();
    check("R10 quick sr exit cmd", 32'(cmd), 32'd7);
    check("R10 quick sr exit pwr", 32'(pwr_state), 32'd0);

    // R11: long low stretch in self-refresh with busy pins
    drive(1'b0, 4'b0001, 2'd0, 14'h0);
    step();
    for (int j = 0; j < 5; j++) begin
      drive(1'b0, 4'(j * 3), 2'(j), 14'(j * 14'h0411));
      step();
      check("R11 sr hold pwr", 32'(pwr_state), 32'd2);
      check("R11 sr hold cmd", {27'd0, illegal, cmd}, 32'd0);
    end

    // R12: bad rise out of self-refresh keeps the state
    drive(1'b1, 4'b0101, 2'd0, 14'h0);
    step();
    check("R12 bad rise pwr", 32'(pwr_state), 32'd2);
    check("R12 bad rise flag", 32'(illegal), 32'd1);

    // R1: reset in self-refresh, then remembered cke is high
    drive(1'b0, 4'b0001, 2'd0, 14'h0);
    step();
    drive(1'b0, 4'b1111, 2'd0, 14'h0);
    step();
    rst_n = 1'b0;
    #1;
    check("R1 async pwr", 32'(pwr_state), 32'd0);
    check("R1 async cmd", 32'(cmd), 32'd0);
    drive(1'b1, 4'b1111, 2'd0, 14'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R1 restart deselect", 32'(cmd), 32'd1);

    // R9: fall with deselect from active
    drive(1'b0, 4'b1010, 2'd3, 14'h0);
    step();
    check("R9 pd entry cmd", 32'(cmd), 32'd13);
    check("R9 pd entry pwr", 32'(pwr_state), 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule